// File: doc/BRIEF.md
# Half-Flash Converter Bus Controller

This block is the digital sequencer of a multichannel 8-bit converter that a host processor reads like a read-only memory. A read access is both active-low strobes, select and read, low at once. It starts a conversion on the channel named by a 3-bit address. The result goes back over a data bus whose tri-state driver is modelled as a value plus an output enable. Two status lines report progress: an active-low interrupt and a ready line. The ready line is an open-drain output, modelled as a pull-low enable. The analog front end is replaced by one digital sample bus per channel. Conversion time is a counted number of clock cycles. The result is built in two steps: a coarse upper nibble taken at the sample point, then a fine lower nibble taken from the residue.

A static mode input picks how the host sees the bus. In stalling mode the host holds its read for the whole conversion: ready holds it off, and the data appears once the result is ready. In pipelined mode a read returns at once with the previous result, and the end of that read starts the next conversion. Ready then carries no information, and the interrupt tells the host when to read again.

Top module: `halfflash_bus_ctrl`

## Requirements
- R1: After reset, intN is 1, dataOe is 0, rdyPullLow is 0 and busyErr is 0.
- R2: In stalling mode (pipeMode=0), a conversion starts at the first clock edge that sees csN and rdN both low. The channel used is the one on chanAddr at that edge, and later address changes do not affect it. The result is the value of that channel at the edge SAMPLE_CYC cycles after the start edge. It appears on dataOut at the edge CONV_CYC cycles after the start edge, and not earlier.
- R3: In stalling mode, dataOe stays 0 while a conversion runs. dataOe becomes 1 at the end-of-conversion edge if the starting read is still held, and it drops once either strobe goes high.
- R4: In stalling mode, rdyPullLow becomes 1 at the edge that first sees csN low, and returns to 0 at the end-of-conversion edge.
- R5: intN goes to 0 at the end-of-conversion edge. It returns to 1 at the first edge that sees csN or rdN high after it was low.
- R6: In pipelined mode (pipeMode=1), dataOe equals (csN and rdN both low), and dataOut shows the result of the most recently completed conversion.
- R7: In pipelined mode, the channel is the chanAddr value held during the last cycle of a read. The conversion starts at the edge where the read is first seen ended, and completes CONV_CYC cycles later, with intN going to 0.
- R8: In pipelined mode, rdyPullLow stays 0.
- R9: The result is the coarse nibble (upper 4 bits of the sample) followed by the fine nibble (sample minus coarse nibble times 16) as straight binary. For codes 0x00, 0x0F, 0x80, 0xF0 and 0xFF it therefore equals the sampled code.
- R10: A read that begins while a conversion runs is ignored: it neither restarts nor extends the conversion, and in pipelined mode its end starts no conversion. busyErr is 1 for exactly one cycle, following the edge where that read was first seen.
- R11: When an end of conversion and a strobe rising edge fall on the same clock edge, setting the interrupt wins and intN goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pipeMode | input | 1 | 0 = stalling mode, 1 = pipelined mode; change only while idle |
| csN | input | 1 | Active-low select strobe |
| rdN | input | 1 | Active-low read strobe |
| chanAddr | input | 3 | Channel address |
| ainBus | input | 64 | Eight 8-bit channel samples, channel n in bits [8n+7:8n] |
| dataOut | output | 8 | Conversion result |
| dataOe | output | 1 | Data bus drive enable (0 = high impedance) |
| intN | output | 1 | Active-low conversion-complete interrupt |
| rdyPullLow | output | 1 | Ready pull-low enable (1 = line pulled low) |
| busyErr | output | 1 | One-cycle flag for a read refused during conversion |

## Verification
The interrupt has two causes that can land on one clock edge: a conversion finishing sets it, and a strobe rising clears it. In pipelined mode the bench starts a read while a conversion runs, so that read is refused. It then releases that read so that the end of the read is seen on exactly the end-of-conversion edge. The expected outcome is intN low afterwards, no new conversion started, and the following read returning the value present at the sample point. A second refused read, released well before completion, shows that completion timing stays unchanged when the edges do not coincide.

// File: rtl/adcif_pkg.sv
`timescale 1ns/1ps
package adcif_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic startStb;      // latch channel address, conversion begins
    logic addrFromHist;  // take the address held during the previous cycle
    logic sampleStb;     // hold the channel sample and coarse nibble
    logic fineStb;       // resolve fine nibble from residue
    logic doneStb;       // publish result
  } convStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } convState_e;

endpackage

// File: rtl/adcif_ctrl.sv
`timescale 1ns/1ps
module adcif_ctrl
  import adcif_pkg::*;
#(
  parameter int CONV_CYC   = 100,
  parameter int SAMPLE_CYC = 50
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pipeMode,
  input  logic         csN,
  input  logic         rdN,
  output convStrobes_t strb,
  output logic         dataOe,
  output logic         intN,
  output logic         rdyPullLow,
  output logic         busyErr
);

  localparam int CNT_W     = $clog2(CONV_CYC);
  localparam int SAMPLE_AT = SAMPLE_CYC - 1;
  localparam int FINE_AT   = CONV_CYC - 2;
  localparam int LAST_AT   = CONV_CYC - 1;

  logic csQ, rdQ;
  logic readAct, readQ, readRise, readEnd;
  logic csFall, csRise, rdRise;
  logic busy, startReq;
  logic ignoreQ, freshQ, intQ, rdyQ, errQ;
  convState_e stateQ;
  logic [CNT_W-1:0] cntQ;

  // strobe history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= 1'b1;
      rdQ <= 1'b1;
    end else begin
      csQ <= csN;
      rdQ <= rdN;
    end
  end

  assign readAct  = !csN && !rdN;
  assign readQ    = !csQ && !rdQ;
  assign readRise = readAct && !readQ;
  assign readEnd  = !readAct && readQ;
  assign csFall   = !csN && csQ;
  assign csRise   = csN && !csQ;
  assign rdRise   = rdN && !rdQ;

  assign busy     = (stateQ == ST_CONV);
  assign startReq = pipeMode ? (readEnd && !ignoreQ) : readRise;

  always_comb begin
    strb              = '0;
    strb.startStb     = !busy && startReq;
    strb.addrFromHist = pipeMode;
    strb.sampleStb    = busy && (cntQ == CNT_W'(SAMPLE_AT));
    strb.fineStb      = busy && (cntQ == CNT_W'(FINE_AT));
    strb.doneStb      = busy && (cntQ == CNT_W'(LAST_AT));
  end

  // conversion sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else if (strb.startStb) begin
      stateQ <= ST_CONV;
      cntQ   <= '0;
    end else if (busy) begin
      if (strb.doneStb) begin
        stateQ <= ST_IDLE;
        cntQ   <= '0;
      end else begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  // refused reads, bus ownership, status lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ignoreQ <= 1'b0;
      freshQ  <= 1'b0;
      intQ    <= 1'b0;
      rdyQ    <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (readRise && busy)  ignoreQ <= 1'b1;
      else if (readEnd)      ignoreQ <= 1'b0;

      if (!readAct)          freshQ <= 1'b0;
      else if (strb.doneStb && !pipeMode && !ignoreQ && !readRise)
                             freshQ <= 1'b1;

      if (strb.doneStb)          intQ <= 1'b1;
      else if (csRise || rdRise) intQ <= 1'b0;

      if (pipeMode || strb.doneStb || csRise) rdyQ <= 1'b0;
      else if (csFall)                        rdyQ <= 1'b1;

      errQ <= readRise && busy;
    end
  end

  assign dataOe     = readAct && (pipeMode || freshQ);
  assign intN       = !intQ;
  assign rdyPullLow = rdyQ;
  assign busyErr    = errQ;

  // R3: no drive of the bus in stalling mode while converting
  assert_bus_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && busy) |-> !dataOe);

  // R4: ready is only released by completion or deselection
  assert_rdy_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyPullLow) |-> $past(strb.doneStb || csN || pipeMode));

  // R5: interrupt only asserts on a completed conversion
  assert_int_on_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(strb.doneStb));

  // R7: pipelined conversions start only on the end of a read
  assert_pipe_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $rose(busy)) |-> $past(readEnd));

  // R10: error flag only follows a busy cycle
  assert_err_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    busyErr |-> $past(busy));

endmodule

// File: rtl/adcif_datapath.sv
`timescale 1ns/1ps
module adcif_datapath
  import adcif_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  convStrobes_t                 strb,
  input  logic [$clog2(NCH)-1:0]       chanAddr,
  input  logic [NCH-1:0][DATA_W-1:0]   ainBus,
  output logic [DATA_W-1:0]            dataOut
);

  localparam int ADDR_W   = $clog2(NCH);
  localparam int COARSE_W = DATA_W / 2;
  localparam int FINE_W   = DATA_W - COARSE_W;

  logic [ADDR_W-1:0]   addrHistQ, addrLatQ;
  logic [NCH-1:0]      chanHit;
  logic [DATA_W-1:0]   selSample, heldSample, coarseScaled, residue, resultQ;
  logic [COARSE_W-1:0] coarseQ;
  logic [FINE_W-1:0]   fineQ;

  // address history and latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHistQ <= '0;
      addrLatQ  <= '0;
    end else begin
      addrHistQ <= chanAddr;
      if (strb.startStb)
        addrLatQ <= strb.addrFromHist ? addrHistQ : chanAddr;
    end
  end

  // channel selection
  for (genvar g = 0; g < NCH; g++) begin : gChanDecode
    assign chanHit[g] = (addrLatQ == ADDR_W'(g));
  end

  always_comb begin
    selSample = '0;
    for (int i = 0; i < NCH; i++)
      if (chanHit[i]) selSample |= ainBus[i];
  end

  // two-step resolution
  assign coarseScaled = {coarseQ, {FINE_W{1'b0}}};
  assign residue      = heldSample - coarseScaled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSample <= '0;
      coarseQ    <= '0;
      fineQ      <= '0;
      resultQ    <= '0;
    end else begin
      if (strb.sampleStb) begin
        heldSample <= selSample;
        coarseQ    <= selSample[DATA_W-1 -: COARSE_W];
      end
      if (strb.fineStb)
        fineQ <= residue[FINE_W-1:0];
      if (strb.doneStb)
        resultQ <= {coarseQ, fineQ};
    end
  end

  assign dataOut = resultQ;

  // R9: the two nibbles together reproduce the held sample
  assert_two_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneStb |=> (dataOut == $past(heldSample)));

endmodule

// File: rtl/halfflash_bus_ctrl.sv
`timescale 1ns/1ps
module halfflash_bus_ctrl
  import adcif_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int DATA_W     = 8,
  parameter int CONV_CYC   = 100,
  parameter int SAMPLE_CYC = 50
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pipeMode,
  input  logic                       csN,
  input  logic                       rdN,
  input  logic [$clog2(NCH)-1:0]     chanAddr,
  input  logic [NCH-1:0][DATA_W-1:0] ainBus,
  output logic [DATA_W-1:0]          dataOut,
  output logic                       dataOe,
  output logic                       intN,
  output logic                       rdyPullLow,
  output logic                       busyErr
);

  convStrobes_t strb;

  adcif_ctrl #(
    .CONV_CYC  (CONV_CYC),
    .SAMPLE_CYC(SAMPLE_CYC)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pipeMode  (pipeMode),
    .csN       (csN),
    .rdN       (rdN),
    .strb      (strb),
    .dataOe    (dataOe),
    .intN      (intN),
    .rdyPullLow(rdyPullLow),
    .busyErr   (busyErr)
  );

  adcif_datapath #(
    .NCH   (NCH),
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .chanAddr(chanAddr),
    .ainBus  (ainBus),
    .dataOut (dataOut)
  );

endmodule

// File: tb/test_halfflash_bus_ctrl.sv
`timescale 1ns/1ps
module test_halfflash_bus_ctrl;

  localparam int NCH  = 8;
  localparam int DW   = 8;
  localparam int CONV = 100;
  localparam int SAMP = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pipeMode = 1'b0;
  logic csN = 1'b1;
  logic rdN = 1'b1;
  logic [2:0] chanAddr = '0;
  logic [NCH-1:0][DW-1:0] ain = '0;
  logic [DW-1:0] dataOut;
  logic dataOe, intN, rdyPullLow, busyErr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] lastRes = '0;

  always #10 clk = ~clk;  // 50 MHz

  halfflash_bus_ctrl #(.NCH(NCH), .DATA_W(DW), .CONV_CYC(CONV), .SAMPLE_CYC(SAMP))
  i_halfflash_bus_ctrl (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .csN(csN), .rdN(rdN),
    .chanAddr(chanAddr), .ainBus(ain), .dataOut(dataOut), .dataOe(dataOe),
    .intN(intN), .rdyPullLow(rdyPullLow), .busyErr(busyErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // two-step code: coarse nibble, then residue nibble
  function automatic logic [7:0] expConv(input logic [7:0] v);
    logic [3:0] coarse;
    logic [7:0] resid;
    coarse = v[7:4];
    resid  = v - {coarse, 4'h0};
    return {coarse, resid[3:0]};
  endfunction

  task automatic scramble();
    for (int i = 0; i < NCH; i++) ain[i] = 8'($urandom);
  endtask

  // stalling-mode read: vB is present at the sample edge
  task automatic waitConv(input int ch, input logic [7:0] vA, input logic [7:0] vB,
                          input logic [7:0] vC);
    logic [7:0] expv;
    @(negedge clk);
    scramble();
    ain[ch] = vA; chanAddr = 3'(ch); csN = 1'b0; rdN = 1'b0;
    @(negedge clk); #1;
    check(rdyPullLow == 1'b1, "R4 ready pulled after select", int'(rdyPullLow), 1);
    check(dataOe == 1'b0, "R3 bus quiet at start", int'(dataOe), 0);
    chanAddr = 3'(ch ^ 5);  // R2: address moved after start
    repeat (SAMP - 1) @(negedge clk);
    ain[ch] = vB;
    @(negedge clk);
    ain[ch] = vC;
    repeat (CONV - SAMP - 1) @(negedge clk);
    #1;
    check(dataOe == 1'b0 && intN == 1'b1, "R2 not complete one cycle early",
          int'({dataOe, intN}), 1);
    check(rdyPullLow == 1'b1, "R4 ready held during conversion", int'(rdyPullLow), 1);
    @(negedge clk); #1;
    expv = expConv(vB);
    check(dataOe == 1'b1, "R3 bus driven at completion", int'(dataOe), 1);
    check(dataOut == expv, "R2 R9 R12 result equals sample-point value",
          int'(dataOut), int'(expv));
    check(rdyPullLow == 1'b0, "R4 ready released at completion", int'(rdyPullLow), 0);
    check(intN == 1'b0, "R5 interrupt at completion", int'(intN), 0);
    lastRes = expv;
    csN = 1'b1; rdN = 1'b1;
    @(negedge clk); #1;
    check(intN == 1'b1, "R5 interrupt cleared by strobe rise", int'(intN), 1);
    check(dataOe == 1'b0, "R3 bus released after read", int'(dataOe), 0);
  endtask

  // pipelined read: returns previous result, starts a conversion at its end
  task automatic pipeConv(input int ch, input logic [7:0] vA, input logic [7:0] vB,
                          input logic [7:0] vC);
    @(negedge clk);
    scramble();
    ain[ch] = vA; chanAddr = 3'(ch ^ 1); csN = 1'b0; rdN = 1'b0;
    @(negedge clk); #1;
    check(dataOe == 1'b1, "R6 bus driven during read", int'(dataOe), 1);
    check(dataOut == lastRes, "R6 previous result returned", int'(dataOut), int'(lastRes));
    check(rdyPullLow == 1'b0, "R8 ready silent", int'(rdyPullLow), 0);
    chanAddr = 3'(ch);
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1; chanAddr = 3'(ch ^ 2);
    repeat (SAMP) @(negedge clk);
    ain[ch] = vB;
    @(negedge clk);
    ain[ch] = vC;
    #1;
    check(intN == 1'b1, "R5 interrupt cleared by read end", int'(intN), 1);
    check(dataOe == 1'b0, "R6 bus released without read", int'(dataOe), 0);
    repeat (CONV - SAMP - 1) @(negedge clk);
    #1;
    check(intN == 1'b1, "R7 not complete one cycle early", int'(intN), 1);
    @(negedge clk); #1;
    check(intN == 1'b0, "R7 complete CONV cycles after read end", int'(intN), 0);
    lastRes = expConv(vB);
  endtask

  // pipelined conversion with a refused read; collide ends it on the completion edge
  task automatic pipeRefused(input int ch, input logic [7:0] v, input bit collide);
    @(negedge clk);
    scramble();
    ain[ch] = v; chanAddr = 3'(ch); csN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;           // end seen at next edge: start
    repeat (5) @(negedge clk);
    csN = 1'b0; rdN = 1'b0;           // begins during conversion
    @(negedge clk); #1;
    check(busyErr == 1'b1, "R10 error flag on refused read", int'(busyErr), 1);
    check(dataOe == 1'b1 && dataOut == lastRes, "R6 old result while converting",
          int'(dataOut), int'(lastRes));
    @(negedge clk); #1;
    check(busyErr == 1'b0, "R10 error flag lasts one cycle", int'(busyErr), 0);
    if (!collide) begin
      csN = 1'b1; rdN = 1'b1;
    end
    repeat (CONV - 7) @(negedge clk);
    #1;
    check(intN == 1'b1, "R10 completion not early", int'(intN), 1);
    if (collide) begin
      csN = 1'b1; rdN = 1'b1;         // strobe rise on the completion edge
    end
    @(negedge clk); #1;
    check(intN == 1'b0, collide ? "R11 set wins over clear" : "R10 timing unchanged",
          int'(intN), 0);
    repeat (3) @(negedge clk);
    #1;
    check(intN == 1'b0, "R10 refused read started nothing", int'(intN), 0);
    lastRes = expConv(v);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    #1;
    check(intN == 1'b1, "R1 reset intN", int'(intN), 1);
    check(dataOe == 1'b0, "R1 reset dataOe", int'(dataOe), 0);
    check(rdyPullLow == 1'b0, "R1 reset rdyPullLow", int'(rdyPullLow), 0);
    check(busyErr == 1'b0, "R1 reset busyErr", int'(busyErr), 0);
    @(negedge clk);
    rstN = 1'b1;

    // stalling mode: directed nibble boundaries, then random
    waitConv(0, 8'h11, 8'h00, 8'hFF);
    waitConv(7, 8'h00, 8'hFF, 8'h00);
    waitConv(3, 8'hA5, 8'h0F, 8'hF0);
    waitConv(4, 8'h3C, 8'hF0, 8'h0F);
    waitConv(2, 8'h7F, 8'h80, 8'h7F);
    for (int i = 0; i < 6; i++)
      waitConv(int'($urandom_range(0, NCH - 1)), 8'($urandom), 8'($urandom), 8'($urandom));

    // pipelined mode
    @(negedge clk);
    pipeMode = 1'b1;
    pipeConv(1, 8'h22, 8'hFF, 8'h00);
    pipeConv(6, 8'h99, 8'h00, 8'hFF);
    for (int i = 0; i < 5; i++)
      pipeConv(int'($urandom_range(0, NCH - 1)), 8'($urandom), 8'($urandom), 8'($urandom));
    pipeRefused(5, 8'hC3, 1'b0);
    pipeConv(2, 8'h10, 8'h5A, 8'h01);
    pipeRefused(3, 8'h6E, 1'b1);
    pipeConv(0, 8'h44, 8'h81, 8'h18);
    pipeConv(7, 8'h00, 8'h00, 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule